// File: doc/BRIEF.md
# Indexed GPIO Wake-Event Configuration Unit

This block watches 64 general-purpose input pins and turns selected transitions or levels on them into power-management wake events. Software reaches every pin through a narrow window instead of a wide register map. It first writes a 6-bit pin index into a select register. It then reads or writes that pin's settings through a single configuration register. Each pin keeps its own settings in a per-pin register file, so moving the select index never disturbs a pin that is not being written.

Only two groups of 16 pins can raise events: the lower half of each 32-pin bank. On these pins the input passes through a two-flop synchronizer and then through an optional debounce filter clocked by a millisecond tick. It is then compared against a programmed polarity, in edge mode or in level mode. A qualifying condition sets a sticky status bit. Software clears that bit by writing a one to it. The single wake output is high whenever any status bit is set. On the other 32 pins the event fields are inert and read back as zero.

Top module: `gpio_wake_cfg`

## Requirements
- R1: Writing address 0 stores bits 5:0 of the write data as the pin index and ignores higher bits. Reading address 0 returns the index in bits 5:0 with all other bits zero. Index bit 5 selects bank 1 (pins 32-63), so index 42 addresses pin 42.
- R2: After reset, the configuration register at address 1 reads 0x44 for an event-capable pin and 0x04 for any other pin.
- R3: The configuration layout is: bit 6 debounce enable, bit 5 polarity (0 low/falling, 1 high/rising), bit 4 mode (0 edge, 1 level), bit 2 pin enable. Bits 31:7, bit 3 and bits 1:0 always read 0, even after writing all ones.
- R4: Pins whose offset within their 32-pin bank is 16 or more store only bit 2. Their bits 6:4 read 0, and no activity on them ever sets a status bit.
- R5: A configuration write changes only the pin currently selected. Every other pin keeps its settings across select changes.
- R6: In edge mode with debounce off, a transition on the pin in the programmed direction sets its status bit 3 clock edges after the pin changes. A transition in the other direction sets nothing.
- R7: In level mode with debounce off, the status bit is set on every cycle the synchronized input equals the programmed polarity. A clear issued while the level still holds leaves the bit set.
- R8: With debounce on, a new input level takes effect only after it has been seen on 16 consecutive tick pulses without the synchronized input returning to the accepted level. Any return restarts the count.
- R9: Address 2 is the status register. Bits 15:0 belong to pins 0-15 and bits 31:16 to pins 32-47. Bits are sticky, a written 1 clears the bit, and a written 0 has no effect.
- R10: The wake output is 1 exactly when at least one status bit is set.
- R11: A capable pin with bit 2 cleared never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 select, 1 configuration, 2 status |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address, combinational |
| pinIn | input | 64 | Raw asynchronous pin levels |
| msTick | input | 1 | One-cycle pulse per millisecond for debouncing |
| pmeOut | output | 1 | Wake event output, OR of all status bits |

## Verification
The bench targets the places where an indirect window goes wrong. These include bank 1 decoding through index bit 5, a write that leaks into a pin other than the selected one, and reserved or non-capable fields that keep written ones. A design with those faults would read back 0x44 or 0x74 where 0x04 or 0x24 is due. The debounce checks use a glitch that returns before the 16th tick, then exactly 15 and then 16 ticks. An off-by-one counter sets status one tick early or late, and a counter that is not restarted sets it after the glitch. Level mode is checked by clearing while the level still holds: a design that gives the clear priority would show a zero. A behavioural model compared every cycle catches a wrong status bit position, a missing synchronizer stage, or an event raised on the wrong edge.

// File: rtl/gwk_pkg.sv
package gwk_pkg;

  // register addresses on the local bus
  localparam int ADDR_SEL = 0;
  localparam int ADDR_CFG = 1;
  localparam int ADDR_STS = 2;

  // bit positions inside the configuration window
  localparam int CFG_DEB_BIT = 6;
  localparam int CFG_POL_BIT = 5;
  localparam int CFG_LVL_BIT = 4;
  localparam int CFG_EN_BIT  = 2;

  typedef struct packed {
    logic debEn;
    logic pol;
    logic lvlMode;
    logic gpEn;
  } gwk_cfg_t;

  typedef struct packed {
    logic selWr;
    logic cfgWr;
    logic stsWr;
  } gwk_strobe_t;

endpackage

// File: rtl/gwk_ctrl.sv
module gwk_ctrl
  import gwk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int IDX_W   = 6,
  parameter int NUM_CAP = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busWdata,
  input  gwk_cfg_t           cfgRd,
  input  logic [NUM_CAP-1:0] stsVec,
  output gwk_strobe_t        strobe,
  output logic [IDX_W-1:0]   selIdx,
  output logic [DATA_W-1:0]  busRdata
);

  logic [IDX_W-1:0] selQ;
  logic hitSel, hitCfg, hitSts;

  assign hitSel = (busAddr == ADDR_W'(ADDR_SEL));
  assign hitCfg = (busAddr == ADDR_W'(ADDR_CFG));
  assign hitSts = (busAddr == ADDR_W'(ADDR_STS));

  always_comb begin
    strobe.selWr = busWr && hitSel;
    strobe.cfgWr = busWr && hitCfg;
    strobe.stsWr = busWr && hitSts;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (strobe.selWr) begin
      selQ <= busWdata[IDX_W-1:0];
    end
  end

  assign selIdx = selQ;

  always_comb begin
    busRdata = '0;
    if (hitSel) begin
      busRdata = DATA_W'(selQ);
    end else if (hitCfg) begin
      busRdata[CFG_DEB_BIT] = cfgRd.debEn;
      busRdata[CFG_POL_BIT] = cfgRd.pol;
      busRdata[CFG_LVL_BIT] = cfgRd.lvlMode;
      busRdata[CFG_EN_BIT]  = cfgRd.gpEn;
    end else if (hitSts) begin
      busRdata = DATA_W'(stsVec);
    end
  end

endmodule

// File: rtl/gwk_wake_cell.sv
module gwk_wake_cell
  import gwk_pkg::*;
#(
  parameter int DEB_TICKS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinRaw,
  input  logic     msTick,
  input  gwk_cfg_t cfg,
  input  logic     clrReq,
  output logic     stsOut
);

  localparam int CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;

  logic syncA, syncB;
  logic debQ, lvlQ, stsQ;
  logic [CNT_W-1:0] cntQ;
  logic filt, hit, edgeHit, levelHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
    end
  end

  // accept a new level after DEB_TICKS ticks of continuous disagreement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debQ <= 1'b0;
      cntQ <= '0;
    end else if (syncB == debQ) begin
      cntQ <= '0;
    end else if (msTick) begin
      if (cntQ == CNT_W'(DEB_TICKS - 1)) begin
        debQ <= syncB;
        cntQ <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign filt     = cfg.debEn ? debQ : syncB;
  assign edgeHit  = cfg.pol ? (filt & ~lvlQ) : (~filt & lvlQ);
  assign levelHit = (filt == cfg.pol);
  assign hit      = cfg.gpEn & (cfg.lvlMode ? levelHit : edgeHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ <= 1'b0;
      stsQ <= 1'b0;
    end else begin
      lvlQ <= filt;
      stsQ <= hit | (stsQ & ~clrReq);
    end
  end

  assign stsOut = stsQ;

endmodule

// File: rtl/gwk_datapath.sv
module gwk_datapath
  import gwk_pkg::*;
#(
  parameter int NUM_PINS     = 64,
  parameter int BANK_SIZE    = 32,
  parameter int CAP_PER_BANK = 16,
  parameter int DEB_TICKS    = 16,
  parameter int DATA_W       = 32,
  parameter int IDX_W        = $clog2(NUM_PINS),
  parameter int NUM_CAP      = (NUM_PINS / BANK_SIZE) * CAP_PER_BANK
) (
  input  logic               clk,
  input  logic               rstN,
  input  gwk_strobe_t        strobe,
  input  logic [IDX_W-1:0]   selIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic               msTick,
  output gwk_cfg_t           cfgRd,
  output logic [NUM_CAP-1:0] stsVec,
  output logic               pmeOut
);

  gwk_cfg_t cfgArr [NUM_PINS];
  gwk_cfg_t wrCfg;

  always_comb begin
    wrCfg.debEn   = wrData[CFG_DEB_BIT];
    wrCfg.pol     = wrData[CFG_POL_BIT];
    wrCfg.lvlMode = wrData[CFG_LVL_BIT];
    wrCfg.gpEn    = wrData[CFG_EN_BIT];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK    = p / BANK_SIZE;
    localparam int OFF     = p % BANK_SIZE;
    localparam int STS_IDX = BANK * CAP_PER_BANK + OFF;

    logic wrThis;
    assign wrThis = strobe.cfgWr && (selIdx == IDX_W'(p));

    if (OFF < CAP_PER_BANK) begin : g_cap
      gwk_cfg_t cfgQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cfgQ <= '{debEn: 1'b1, pol: 1'b0, lvlMode: 1'b0, gpEn: 1'b1};
        end else if (wrThis) begin
          cfgQ <= wrCfg;
        end
      end

      assign cfgArr[p] = cfgQ;

      gwk_wake_cell #(.DEB_TICKS(DEB_TICKS)) u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .pinRaw (pinIn[p]),
        .msTick (msTick),
        .cfg    (cfgQ),
        .clrReq (strobe.stsWr && wrData[STS_IDX]),
        .stsOut (stsVec[STS_IDX])
      );
    end else begin : g_plain
      logic enQ;
      logic unusedPin;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ <= 1'b1;
        end else if (wrThis) begin
          enQ <= wrCfg.gpEn;
        end
      end

      assign cfgArr[p] = '{debEn: 1'b0, pol: 1'b0, lvlMode: 1'b0, gpEn: enQ};
      assign unusedPin = pinIn[p];
    end
  end

  assign cfgRd  = cfgArr[selIdx];
  assign pmeOut = |stsVec;

endmodule

// File: rtl/gpio_wake_cfg.sv
module gpio_wake_cfg
  import gwk_pkg::*;
#(
  parameter int NUM_PINS     = 64,
  parameter int BANK_SIZE    = 32,
  parameter int CAP_PER_BANK = 16,
  parameter int DEB_TICKS    = 16,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                msTick,
  output logic                pmeOut
);

  localparam int IDX_W   = $clog2(NUM_PINS);
  localparam int NUM_CAP = (NUM_PINS / BANK_SIZE) * CAP_PER_BANK;

  gwk_strobe_t        strobe;
  gwk_cfg_t           cfgRd;
  logic [IDX_W-1:0]   selIdx;
  logic [NUM_CAP-1:0] stsVec;

  gwk_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .NUM_CAP(NUM_CAP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busWdata(busWdata),
    .cfgRd   (cfgRd),
    .stsVec  (stsVec),
    .strobe  (strobe),
    .selIdx  (selIdx),
    .busRdata(busRdata)
  );

  gwk_datapath #(
    .NUM_PINS    (NUM_PINS),
    .BANK_SIZE   (BANK_SIZE),
    .CAP_PER_BANK(CAP_PER_BANK),
    .DEB_TICKS   (DEB_TICKS),
    .DATA_W      (DATA_W),
    .IDX_W       (IDX_W),
    .NUM_CAP     (NUM_CAP)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .selIdx (selIdx),
    .wrData (busWdata),
    .pinIn  (pinIn),
    .msTick (msTick),
    .cfgRd  (cfgRd),
    .stsVec (stsVec),
    .pmeOut (pmeOut)
  );

endmodule

// File: rtl/gwk_checker.sv
module gwk_checker
  import gwk_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 2,
  parameter int IDX_W        = 6,
  parameter int NUM_CAP      = 32,
  parameter int BANK_SIZE    = 32,
  parameter int CAP_PER_BANK = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [IDX_W-1:0]   selIdx,
  input logic [NUM_CAP-1:0] stsVec
);

  // R1: the index written last cycle is what the select register returns
  a_r1_sel_readback: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(ADDR_SEL)) |=>
      (busAddr != ADDR_W'(ADDR_SEL)) || (busRdata[IDX_W-1:0] == $past(busWdata[IDX_W-1:0])));

  // R1: bits above the index never read as one
  a_r1_sel_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_SEL)) |-> (busRdata[DATA_W-1:IDX_W] == '0));

  // R3: reserved configuration bits read as zero
  a_r3_cfg_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_CFG)) |->
      (busRdata[DATA_W-1:7] == '0) && !busRdata[3] && (busRdata[1:0] == 2'b00));

  // R4: pins without event logic show no event fields
  a_r4_noncap_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((busAddr == ADDR_W'(ADDR_CFG)) && ((int'(selIdx) % BANK_SIZE) >= CAP_PER_BANK)) |->
      (busRdata[6:4] == 3'b000));

  // R9: without a status write no status bit drops
  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == ADDR_W'(ADDR_STS)) |=> ((stsVec & $past(stsVec)) == $past(stsVec)));

endmodule

bind gpio_wake_cfg gwk_checker #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .IDX_W       (IDX_W),
  .NUM_CAP     (NUM_CAP),
  .BANK_SIZE   (BANK_SIZE),
  .CAP_PER_BANK(CAP_PER_BANK)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .selIdx  (selIdx),
  .stsVec  (stsVec)
);

// File: tb/tb_gpio_wake_cfg.sv
`timescale 1ns/1ps
module tb_gpio_wake_cfg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] pinIn = '0;
  logic        msTick = 1'b0;
  logic        pmeOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_wake_cfg dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .msTick(msTick), .pmeOut(pmeOut)
  );

  // ---------------- behavioural reference model ----------------
  bit m_s1[64], m_s2[64], m_deb[64], m_prev[64];
  int m_cnt[64];
  bit m_debEn[64], m_pol[64], m_lvl[64], m_en[64];
  bit [31:0] m_sts;
  int m_sel;

  function automatic bit capable(int p);
    return (p % 32) < 16;
  endfunction

  function automatic int stsBit(int p);
    return (p / 32) * 16 + (p % 32);
  endfunction

  function automatic logic [31:0] modelRead(logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: v = 32'(m_sel);
      2'd1: begin
        v[2] = m_en[m_sel];
        if (capable(m_sel)) begin
          v[6] = m_debEn[m_sel];
          v[5] = m_pol[m_sel];
          v[4] = m_lvl[m_sel];
        end
      end
      2'd2: v = m_sts;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m_sts = '0;
      m_sel = 0;
      for (int p = 0; p < 64; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_deb[p] = 0; m_prev[p] = 0; m_cnt[p] = 0;
        m_debEn[p] = capable(p); m_pol[p] = 0; m_lvl[p] = 0; m_en[p] = 1;
      end
    end else begin
      for (int p = 0; p < 64; p++) begin
        if (capable(p)) begin
          bit f, hit;
          int k;
          k = stsBit(p);
          f = m_debEn[p] ? m_deb[p] : m_s2[p];
          if (m_lvl[p]) hit = (f == m_pol[p]);
          else hit = m_pol[p] ? (f && !m_prev[p]) : (!f && m_prev[p]);
          hit = hit && m_en[p];
          if (hit) m_sts[k] = 1;
          else if (busWr && busAddr == 2'd2 && busWdata[k]) m_sts[k] = 0;
          m_prev[p] = f;
          if (m_s2[p] == m_deb[p]) m_cnt[p] = 0;
          else if (msTick) begin
            if (m_cnt[p] == 15) begin m_deb[p] = m_s2[p]; m_cnt[p] = 0; end
            else m_cnt[p]++;
          end
        end
        m_s2[p] = m_s1[p];
        m_s1[p] = pinIn[p];
      end
      if (busWr && busAddr == 2'd1) begin
        m_en[m_sel] = busWdata[2];
        if (capable(m_sel)) begin
          m_debEn[m_sel] = busWdata[6];
          m_pol[m_sel]   = busWdata[5];
          m_lvl[m_sel]   = busWdata[4];
        end
      end
      if (busWr && busAddr == 2'd0) m_sel = int'(busWdata[5:0]);
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && !done) begin
        check("R10 model pme", 32'(pmeOut), 32'(m_sts != 0));
        check("R9 model rdata", busRdata, modelRead(busAddr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic writeReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic readReg(logic [1:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic giveTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // reset state
    readReg(2'd1, v); check("R2 reset cfg pin0", v, 32'h44);
    readReg(2'd2, v); check("R9 reset status", v, 32'h0);
    check("R10 reset pme", 32'(pmeOut), 32'h0);

    // select register, bank 1 via bit 5
    writeReg(2'd0, 32'hFFFF_FFEA);
    readReg(2'd0, v); check("R1 select readback", v, 32'h2A);
    readReg(2'd1, v); check("R1 bank1 pin42 cfg", v, 32'h44);
    writeReg(2'd0, 32'd51);
    readReg(2'd1, v); check("R2 noncap reset cfg", v, 32'h04);

    // non-capable pin ignores event fields and activity
    writeReg(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, v); check("R3 R4 noncap all-ones", v, 32'h04);
    @(negedge clk); pinIn[51] = 1'b1;
    idle(5); pinIn[51] = 1'b0;
    idle(5);
    readReg(2'd2, v); check("R4 noncap no status", v, 32'h0);

    // per-pin storage
    writeReg(2'd0, 32'd3);
    writeReg(2'd1, 32'hFFFF_FF24);
    writeReg(2'd0, 32'd42);
    readReg(2'd1, v); check("R5 pin42 untouched", v, 32'h44);
    writeReg(2'd0, 32'd3);
    readReg(2'd1, v); check("R3 R5 pin3 stored", v, 32'h24);

    // edge mode, rising polarity, pin 3
    @(negedge clk); pinIn[3] = 1'b1;
    idle(2);
    readReg(2'd2, v); check("R6 not yet after 2 edges", v, 32'h0);
    idle(1);
    readReg(2'd2, v); check("R6 set after 3 edges", v, 32'h8);
    check("R10 pme high", 32'(pmeOut), 32'h1);
    writeReg(2'd2, 32'h0);
    readReg(2'd2, v); check("R9 zero write keeps", v, 32'h8);
    writeReg(2'd2, 32'h8);
    readReg(2'd2, v); check("R9 w1c clears", v, 32'h0);
    check("R10 pme low", 32'(pmeOut), 32'h0);
    @(negedge clk); pinIn[3] = 1'b0;
    idle(5);
    readReg(2'd2, v); check("R6 opposite edge ignored", v, 32'h0);

    // level mode, low active, pin 42 -> status bit 26
    writeReg(2'd0, 32'd42);
    writeReg(2'd1, 32'h14);
    idle(1);
    readReg(2'd2, v); check("R7 level sets", v, 32'h0400_0000);
    writeReg(2'd2, 32'h0400_0000);
    readReg(2'd2, v); check("R7 clear while level holds", v, 32'h0400_0000);
    @(negedge clk); pinIn[42] = 1'b1;
    idle(3);
    writeReg(2'd2, 32'h0400_0000);
    idle(1);
    readReg(2'd2, v); check("R7 inactive level clears", v, 32'h0);

    // pin enable cleared, pin 5
    writeReg(2'd0, 32'd5);
    writeReg(2'd1, 32'h20);
    @(negedge clk); pinIn[5] = 1'b1;
    idle(5);
    readReg(2'd2, v); check("R11 disabled pin quiet", v, 32'h0);

    // debounce, rising, pin 7
    writeReg(2'd0, 32'd7);
    writeReg(2'd1, 32'h64);
    @(negedge clk); pinIn[7] = 1'b1;
    idle(3);
    giveTicks(10);
    @(negedge clk); pinIn[7] = 1'b0;
    idle(3);
    @(negedge clk); pinIn[7] = 1'b1;
    idle(3);
    giveTicks(15);
    idle(3);
    readReg(2'd2, v); check("R8 15 ticks after glitch", v, 32'h0);
    giveTicks(1);
    idle(3);
    readReg(2'd2, v); check("R8 16th tick accepts", v, 32'h80);

    idle(2);
    finishRun();
  end

endmodule